// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder, 64 bits

This block adds two 64-bit unsigned operands plus a one-bit carry-in and returns the 64-bit sum and the carry-out. It is purely combinational and is meant to sit inside a datapath stage where a ripple adder would be too slow.

Internally the operands are cut into sixteen 4-bit groups. Each group forms per-bit propagate (a XOR b) and generate (a AND b) signals and derives its own bit carries by lookahead. Four groups make a 16-bit section, whose lookahead unit produces the carry into each group. Four sections feed a top lookahead unit, which produces the carry into each section and the final carry-out.

Every carry in the tree is a flat sum of products. No carry waits for a neighbour's carry. The propagate and generate passed up each level leave out the carry-in term. This keeps the tree free of combinational loops.

Top module: `cla64_adder`

## Requirements
- R1: `sum_o` equals bits 63:0 of the 65-bit value `a_i + b_i + carry_i`, for any operands.
- R2: `carry_o` equals bit 64 of that 65-bit value.
- R3: With both operands all ones, or with `a_i` all ones, `b_i` equal to 1 and `carry_i` = 0, `sum_o` matches R1 and `carry_o` is 1.
- R4: With both operands zero and `carry_i` = 1, `sum_o` is 1 and `carry_o` is 0. With `carry_i` = 0, both outputs are zero.
- R5: When every bit position propagates (`a_i ^ b_i` is all ones), `carry_o` equals `carry_i`. In that case `sum_o` is all ones for `carry_i` = 0 and all zeros for `carry_i` = 1.
- R6: Take `a_i` = 1 shifted left by k and `b_i` = all ones shifted left by k, with `carry_i` = 0. For every k from 0 to 63, `sum_o` is zero and `carry_o` is 1. A carry made in any bit therefore crosses every group and section boundary above it.
- R7: With equal operands, `sum_o` equals the operand shifted left by one with `carry_i` in bit 0, and `carry_o` equals operand bit 63. This covers the alternating patterns 0x5555... and 0xAAAA...

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum bits 63:0 |
| carry_o | output | 1 | Carry out of bit 63 |

## Verification
A wrong carry inside a group flips sum bits only within that nibble. A wrong carry into a group or a section flips the lowest sum bit of that group or section. Since there is no state, either fault shows on `sum_o` in the same evaluation as the operands that exercise it.

For this reason the bench sweeps all 512 input combinations of one nibble at every one of the sixteen group positions, with the higher bits set to propagate. Any misrouted group or section carry then reaches `carry_o` or the upper sum bits. The generate-at-bit-k walk and the random vectors cover mixed propagate and generate patterns.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;
  localparam int GRP_W   = 4;                  // bits per group
  localparam int FANOUT  = 4;                  // groups per section
  localparam int SEC_N   = 4;                  // sections per adder
  localparam int SEC_W   = GRP_W * FANOUT;
  localparam int DATA_W  = SEC_W * SEC_N;
endpackage

// File: rtl/cla_lookahead.sv
`timescale 1ns/1ps
// N-input lookahead unit: flat SOP carries, block p/g without carry-in term
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         c_i,
  output logic [N-1:0] c_o,
  output logic         cout_o,
  output logic         p_o,
  output logic         g_o
);
  logic [N:0] cy;

  // block propagate/generate: independent of c_i
  always_comb begin
    logic term;
    p_o = &p_i;
    g_o = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = g_i[j];
      for (int m = 0; m < N; m++)
        if (m > j) term = term & p_i[m];
      g_o = g_o | term;
    end
  end

  // each carry expanded as its own sum of products
  always_comb begin
    logic term;
    cy[0] = c_i;
    for (int k = 1; k <= N; k++) begin
      term = c_i;
      for (int m = 0; m < N; m++)
        if (m < k) term = term & p_i[m];
      cy[k] = term;
      for (int j = 0; j < N; j++) begin
        if (j < k) begin
          term = g_i[j];
          for (int m = 0; m < N; m++)
            if (m > j && m < k) term = term & p_i[m];
          cy[k] = cy[k] | term;
        end
      end
    end
  end

  assign c_o    = cy[N-1:0];
  assign cout_o = cy[N];

  // R5: an input slot never both propagates and generates
  always_comb begin
    for (int j = 0; j < N; j++)
      a_r5_pg_excl: assert (!(p_i[j] && g_i[j]))
        else $error("a_r5_pg_excl slot %0d", j);
  end

  // R2: expanded carry-out agrees with block generate/propagate
  always_comb begin
    a_r2_cout_pg: assert (cout_o == (g_o | (p_o & c_i)))
      else $error("a_r2_cout_pg");
  end
endmodule

// File: rtl/cla_group.sv
`timescale 1ns/1ps
module cla_group
  import cla_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         p_o,
  output logic         g_o,
  output logic         cout_o
);
  logic [W-1:0] bit_p, bit_g, bit_c;

  assign bit_p = a_i ^ b_i;
  assign bit_g = a_i & b_i;

  cla_lookahead #(.N(W)) u_la (
    .p_i   (bit_p),
    .g_i   (bit_g),
    .c_i   (c_i),
    .c_o   (bit_c),
    .cout_o(cout_o),
    .p_o   (p_o),
    .g_o   (g_o)
  );

  assign s_o = bit_p ^ bit_c;
endmodule

// File: rtl/cla_section.sv
`timescale 1ns/1ps
module cla_section
  import cla_pkg::*;
#(
  parameter int GW  = GRP_W,
  parameter int FAN = FANOUT,
  localparam int W  = GW * FAN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         p_o,
  output logic         g_o,
  output logic         cout_o
);
  logic [FAN-1:0] grp_p, grp_g, grp_c, grp_cout;

  for (genvar j = 0; j < FAN; j++) begin : g_grp
    cla_group #(.W(GW)) u_grp (
      .a_i   (a_i[j*GW +: GW]),
      .b_i   (b_i[j*GW +: GW]),
      .c_i   (grp_c[j]),
      .s_o   (s_o[j*GW +: GW]),
      .p_o   (grp_p[j]),
      .g_o   (grp_g[j]),
      .cout_o(grp_cout[j])
    );
  end

  cla_lookahead #(.N(FAN)) u_la (
    .p_i   (grp_p),
    .g_i   (grp_g),
    .c_i   (c_i),
    .c_o   (grp_c),
    .cout_o(cout_o),
    .p_o   (p_o),
    .g_o   (g_o)
  );

  // R2: group's internal carry-out matches lookahead carry into next group
  always_comb begin
    for (int j = 0; j < FAN - 1; j++)
      a_r2_grp_chain: assert (grp_cout[j] == grp_c[j+1])
        else $error("a_r2_grp_chain group %0d", j);
    a_r2_grp_top: assert (grp_cout[FAN-1] == cout_o)
      else $error("a_r2_grp_top");
  end
endmodule

// File: rtl/cla64_adder.sv
`timescale 1ns/1ps
module cla64_adder
  import cla_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o
);
  logic [SEC_N-1:0] sec_p, sec_g, sec_c, sec_cout;

  for (genvar k = 0; k < SEC_N; k++) begin : g_sec
    cla_section #(.GW(GRP_W), .FAN(FANOUT)) u_sec (
      .a_i   (a_i[k*SEC_W +: SEC_W]),
      .b_i   (b_i[k*SEC_W +: SEC_W]),
      .c_i   (sec_c[k]),
      .s_o   (sum_o[k*SEC_W +: SEC_W]),
      .p_o   (sec_p[k]),
      .g_o   (sec_g[k]),
      .cout_o(sec_cout[k])
    );
  end

  // second-level unit: carries back into sections, final carry-out
  cla_lookahead #(.N(SEC_N)) u_la_top (
    .p_i   (sec_p),
    .g_i   (sec_g),
    .c_i   (carry_i),
    .c_o   (sec_c),
    .cout_o(carry_o),
    .p_o   (),
    .g_o   ()
  );

  always_comb begin
    for (int k = 0; k < SEC_N - 1; k++)
      a_r2_sec_chain: assert (sec_cout[k] == sec_c[k+1])
        else $error("a_r2_sec_chain section %0d", k);
    a_r2_sec_top: assert (sec_cout[SEC_N-1] == carry_o)
      else $error("a_r2_sec_top");
    a_r5_full_prop: assert (!(&(a_i ^ b_i)) || (carry_o == carry_i))
      else $error("a_r5_full_prop");
    a_r3_all_gen: assert (!(&(a_i & b_i)) || carry_o)
      else $error("a_r3_all_gen");
  end
endmodule

// File: tb/cla64_adder_tb.sv
`timescale 1ns/1ps
module cla64_adder_tb;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  cla64_adder u_dut (
    .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum), .carry_o(cout)
  );

  task automatic chk_val(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0b act=%h exp=%h", tag, a, b, cin, act, exp);
    end
  endtask

  // apply on posedge, sample on following negedge
  task automatic run(input logic [W-1:0] av, input logic [W-1:0] bv,
                     input logic cv, input string tag);
    logic [W:0] ref_v;
    @(posedge clk);
    a = av; b = bv; cin = cv;
    ref_v = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    @(negedge clk);
    chk_val({tag, " R1 sum"}, sum, ref_v[W-1:0]);
    chk_val({tag, " R2 carry"}, {{W-1{1'b0}}, cout}, {{W-1{1'b0}}, ref_v[W]});
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    // R4: idle/zero state
    chk_val("R4 zero state sum", sum, '0);
    chk_val("R4 zero state carry", {{W-1{1'b0}}, cout}, '0);

    // R3: all ones corners
    run('1, 64'd1, 1'b0, "R3 ones+1");
    chk_val("R3 ones+1 sum zero", sum, '0);
    chk_val("R3 ones+1 carry", {{W-1{1'b0}}, cout}, 64'd1);
    run('1, '1, 1'b1, "R3 ones+ones+1");
    chk_val("R3 ones+ones carry", {{W-1{1'b0}}, cout}, 64'd1);

    // R4: zero plus carry-in
    run('0, '0, 1'b1, "R4 zero+cin");
    chk_val("R4 zero+cin sum", sum, 64'd1);
    chk_val("R4 zero+cin carry", {{W-1{1'b0}}, cout}, '0);

    // R5: full propagate, both carry-in values
    for (int i = 0; i < 20; i++) begin
      v = rnd64();
      for (int c = 0; c < 2; c++) begin
        run(v, ~v, c[0], "R5 full prop");
        chk_val("R5 sum", sum, c[0] ? '0 : '1);
        chk_val("R5 carry", {{W-1{1'b0}}, cout}, {{W-1{1'b0}}, c[0]});
      end
    end
    run(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R5 alt");

    // R6: generate at bit k crosses every higher boundary
    for (int k = 0; k < W; k++) begin
      run(64'd1 << k, {W{1'b1}} << k, 1'b0, "R6 gen walk");
      chk_val("R6 sum zero", sum, '0);
      chk_val("R6 carry", {{W-1{1'b0}}, cout}, 64'd1);
    end

    // R7: equal operands, alternating patterns included
    run(64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b0, "R7 alt5");
    chk_val("R7 alt5 sum", sum, 64'hAAAA_AAAA_AAAA_AAAA);
    run(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R7 altA");
    chk_val("R7 altA sum", sum, 64'h5555_5555_5555_5555);
    chk_val("R7 altA carry", {{W-1{1'b0}}, cout}, 64'd1);
    for (int i = 0; i < 50; i++) begin
      v = rnd64();
      run(v, v, i[0], "R7 equal");
      chk_val("R7 shift", sum, {v[W-2:0], i[0]});
      chk_val("R7 carry", {{W-1{1'b0}}, cout}, {{W-1{1'b0}}, v[W-1]});
    end

    // R1/R2: exhaustive nibble at every group position, higher bits propagate
    for (int g = 0; g < W / 4; g++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            logic [W-1:0] av, bv;
            av = ~({W{1'b0}} | (64'hF << (4 * g)));
            av = av | (64'(x) << (4 * g));
            bv = 64'(y) << (4 * g);
            run(av, bv, c[0], "R1 R2 nibble sweep");
          end

    // R1/R2: random vectors
    for (int i = 0; i < 10000; i++)
      run(rnd64(), rnd64(), $urandom_range(0, 1) == 1, "R1 R2 random");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule